// File: doc/BRIEF.md
# Privileged Status and Flag Register Unit

This unit holds two processor state registers behind a move-to/move-from special-register port. The supervision register sets the operating mode, the recognition enables for exceptions and external interrupts, the cache and MMU enables, the little-endian enable and a 4-bit context number. It can be read or written only while the processor runs in supervisor mode. The flag register holds the compare, carry and overflow flags. Both modes can reach it, and the execution datapath also loads it through per-flag update strobes.

The supervision register's fields drive dedicated output pins, so the rest of the core sees them without an access cycle. A user-mode access to the supervision register is refused: the read returns zero, the write is dropped, and a privilege-violation pulse appears in the same cycle as the access strobe. The core's trap logic takes that pulse. Special-register addresses are 16 bits wide. The top four bits select one of sixteen groups, and this unit answers only in group 0.

Top module: `prv_state_unit`

## Requirements
- R1: After reset the supervision register reads 0x00000001. Supervisor mode is on, every enable is off, the context is 0, and all three flags are 0.
- R2: A supervisor-mode write to address 0x0011 stores bits 31:28 and 7:0. Bits 27:8 always read back as zero.
- R3: In the cycle after the write edge, the control pins follow the stored supervision bits. The mapping is bit 0 `supv`, bit 1 `exc_en`, bit 2 `irq_en`, bit 3 `dc_en`, bit 4 `ic_en`, bit 5 `dmmu_en`, bit 6 `immu_en`, bit 7 `le_en`, and bits 31:28 `ctx_id`.
- R4: While `supv` is 0, any read or write strobe aimed at 0x0011 raises `priv_fault` in the same cycle. Such a read returns zero and such a write leaves the register unchanged. Once user mode is entered, only reset returns the unit to supervisor mode.
- R5: The flag register at address 0x0010 can be read and written in both modes without a fault. Bit 0 is compare, bit 1 is carry and bit 2 is overflow, and bits 31:3 read as zero.
- R6: Each hardware update strobe `flag_upd_we[i]` loads `flag_upd_val[i]` into its flag at the next edge. The bit order is 0 compare, 1 carry, 2 overflow. A flag whose strobe is low keeps its value.
- R7: When a software write to the flag register and hardware update strobes fall in the same cycle, the software data is stored in all three flags.
- R8: The group is taken from address bits 15:12. Any address other than 0x0010 and 0x0011 reads zero, changes no state and raises no fault. This includes 0x1011 and 0x1010.
- R9: Read data appears combinationally in the cycle of the read strobe, and `spr_rdata` is zero whenever `spr_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spr_addr | input | 16 | Special-register address |
| spr_wdata | input | 32 | Move-to write data |
| spr_we | input | 1 | Write strobe |
| spr_re | input | 1 | Read strobe |
| flag_upd_we | input | 3 | Per-flag hardware update strobes (0 compare, 1 carry, 2 overflow) |
| flag_upd_val | input | 3 | Values for the hardware updates |
| spr_rdata | output | 32 | Move-from read data |
| priv_fault | output | 1 | Privilege violation on the supervision register |
| supv | output | 1 | Supervisor mode |
| exc_en | output | 1 | Exception recognition enable |
| irq_en | output | 1 | External interrupt recognition enable |
| dc_en | output | 1 | Data cache enable |
| ic_en | output | 1 | Instruction cache enable |
| dmmu_en | output | 1 | Data MMU enable |
| immu_en | output | 1 | Instruction MMU enable |
| le_en | output | 1 | Little-endian enable |
| ctx_id | output | 4 | Current context number |

## Verification
Read data and `priv_fault` are combinational, so the bench samples them 1 ns after driving a strobe on the falling edge, inside that same cycle. Register writes and flag updates take effect at the following rising edge. Control pins and flag read-back are therefore checked on the next falling edge, one cycle after the stimulus and never earlier. The user-mode scenario runs last and ends with a reset, so the refused accesses can be judged against a known supervision value.

// File: rtl/prv_state_pkg.sv
package prv_state_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int GRP_W  = 4;
  localparam int NFLAG  = 3;

  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 16'h0010;
  localparam logic [ADDR_W-1:0] ADDR_SUPER = 16'h0011;
  localparam logic [DATA_W-1:0] SUPER_RESET = 32'h0000_0001;
  localparam logic [DATA_W-1:0] SUPER_MASK  = 32'hF000_00FF;

  typedef enum logic [1:0] {SEL_NONE, SEL_FLAGS, SEL_SUPER} spr_sel_e;

  function automatic logic [GRP_W-1:0] grp_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: GRP_W];
  endfunction

  function automatic logic [DATA_W-1:0] super_keep(input logic [DATA_W-1:0] d);
    return d & SUPER_MASK;
  endfunction

  function automatic logic [DATA_W-1:0] flags_word(input logic [NFLAG-1:0] f);
    return {{(DATA_W-NFLAG){1'b0}}, f};
  endfunction
endpackage

// File: rtl/prv_spr_decode.sv
module prv_spr_decode
  import prv_state_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic          re,
  input  logic          supv,
  output spr_sel_e      sel,
  output logic          super_wr,
  output logic          flags_wr,
  output logic          viol
);
  localparam int IDX_W = AW - GRP_W;

  logic in_grp0, hit_super, hit_flags;

  always_comb begin
    in_grp0   = (grp_of(addr) == '0);
    hit_super = in_grp0 && (addr[IDX_W-1:0] == ADDR_SUPER[IDX_W-1:0]);
    hit_flags = in_grp0 && (addr[IDX_W-1:0] == ADDR_FLAGS[IDX_W-1:0]);
    if (hit_super)      sel = SEL_SUPER;
    else if (hit_flags) sel = SEL_FLAGS;
    else                sel = SEL_NONE;
    super_wr = hit_super && we && supv;
    flags_wr = hit_flags && we;
    viol     = hit_super && (we || re) && !supv;
  end
endmodule

// File: rtl/prv_super_reg.sv
module prv_super_reg
  import prv_state_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= SUPER_RESET;
    else if (wr) q <= super_keep(wdata);
  end
endmodule

// File: rtl/prv_flag_reg.sv
module prv_flag_reg
  import prv_state_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [NF-1:0] sw_data,
  input  logic [NF-1:0] hw_we,
  input  logic [NF-1:0] hw_val,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= 1'b0;
      else if (sw_wr)     q[i] <= sw_data[i];
      else if (hw_we[i])  q[i] <= hw_val[i];
    end
  end
endmodule

// File: rtl/prv_state_unit.sv
module prv_state_unit
  import prv_state_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] spr_addr,
  input  logic [DATA_W-1:0] spr_wdata,
  input  logic              spr_we,
  input  logic              spr_re,
  input  logic [NFLAG-1:0]  flag_upd_we,
  input  logic [NFLAG-1:0]  flag_upd_val,
  output logic [DATA_W-1:0] spr_rdata,
  output logic              priv_fault,
  output logic              supv,
  output logic              exc_en,
  output logic              irq_en,
  output logic              dc_en,
  output logic              ic_en,
  output logic              dmmu_en,
  output logic              immu_en,
  output logic              le_en,
  output logic [3:0]        ctx_id
);
  spr_sel_e          sel;
  logic              super_wr, flags_wr, viol;
  logic [DATA_W-1:0] super_q;
  logic [NFLAG-1:0]  flags_q;

  prv_spr_decode #(.AW(ADDR_W)) u_dec (
    .addr(spr_addr), .we(spr_we), .re(spr_re), .supv(super_q[0]),
    .sel(sel), .super_wr(super_wr), .flags_wr(flags_wr), .viol(viol)
  );

  prv_super_reg #(.DW(DATA_W)) u_super (
    .clk(clk), .rst_n(rst_n), .wr(super_wr), .wdata(spr_wdata), .q(super_q)
  );

  prv_flag_reg #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .sw_wr(flags_wr), .sw_data(spr_wdata[NFLAG-1:0]),
    .hw_we(flag_upd_we), .hw_val(flag_upd_val), .q(flags_q)
  );

  always_comb begin
    spr_rdata = '0;
    if (spr_re) begin
      unique case (sel)
        SEL_FLAGS: spr_rdata = flags_word(flags_q);
        SEL_SUPER: spr_rdata = super_q[0] ? super_q : '0;
        default:   spr_rdata = '0;
      endcase
    end
  end

  assign priv_fault = viol;
  assign supv    = super_q[0];
  assign exc_en  = super_q[1];
  assign irq_en  = super_q[2];
  assign dc_en   = super_q[3];
  assign ic_en   = super_q[4];
  assign dmmu_en = super_q[5];
  assign immu_en = super_q[6];
  assign le_en   = super_q[7];
  assign ctx_id  = super_q[DATA_W-1 -: 4];
endmodule

// File: rtl/prv_state_chk.sv
module prv_state_chk
  import prv_state_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] spr_addr,
  input logic [DATA_W-1:0] spr_wdata,
  input logic              spr_we,
  input logic              spr_re,
  input logic [NFLAG-1:0]  flag_upd_we,
  input logic [DATA_W-1:0] spr_rdata,
  input logic              priv_fault,
  input logic              supv,
  input logic [DATA_W-1:0] super_q,
  input logic [NFLAG-1:0]  flags_q
);
  a_r4_fault_only_user: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> !supv);

  a_r4_user_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !supv |=> !supv);

  a_r4_user_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_fault && spr_we) |=> $stable(super_q));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    super_q[27:8] == '0);

  a_r7_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && spr_addr == ADDR_FLAGS) |=> flags_q == $past(spr_wdata[NFLAG-1:0]));

  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd_we == '0 && !(spr_we && spr_addr == ADDR_FLAGS)) |=> $stable(flags_q));

  a_r8_other_group: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && grp_of(spr_addr) != '0) |=> ($stable(super_q) && $stable(flags_q)));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !spr_re |-> spr_rdata == '0);
endmodule

bind prv_state_unit prv_state_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
  .spr_we(spr_we), .spr_re(spr_re), .flag_upd_we(flag_upd_we),
  .spr_rdata(spr_rdata), .priv_fault(priv_fault), .supv(supv),
  .super_q(super_q), .flags_q(flags_q)
);

// File: tb/prv_state_unit_test.sv
`timescale 1ns/1ps
module prv_state_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] spr_addr = '0;
  logic [31:0] spr_wdata = '0;
  logic        spr_we = 1'b0, spr_re = 1'b0;
  logic [2:0]  flag_upd_we = '0, flag_upd_val = '0;
  logic [31:0] spr_rdata;
  logic        priv_fault, supv, exc_en, irq_en, dc_en, ic_en, dmmu_en, immu_en, le_en;
  logic [3:0]  ctx_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [15:0] A_FLG = 16'h0010;
  localparam logic [15:0] A_SUP = 16'h0011;

  always #2 clk = ~clk;

  prv_state_unit uut (
    .clk(clk), .rst_n(rst_n), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
    .spr_we(spr_we), .spr_re(spr_re), .flag_upd_we(flag_upd_we),
    .flag_upd_val(flag_upd_val), .spr_rdata(spr_rdata), .priv_fault(priv_fault),
    .supv(supv), .exc_en(exc_en), .irq_en(irq_en), .dc_en(dc_en), .ic_en(ic_en),
    .dmmu_en(dmmu_en), .immu_en(immu_en), .le_en(le_en), .ctx_id(ctx_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pins();
    return {ctx_id, 20'h0, le_en, immu_en, dmmu_en, ic_en, dc_en, irq_en, exc_en, supv};
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    spr_addr = a; spr_wdata = d; spr_we = 1'b1;
    @(negedge clk);
    spr_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic f);
    @(negedge clk);
    spr_addr = a; spr_re = 1'b1;
    #1 d = spr_rdata; f = priv_fault;
    @(negedge clk);
    spr_re = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic f;
    check("R1 pins", pins(), 32'h1);
    rd(A_SUP, d, f); check("R1 super read", d, 32'h1);
    rd(A_FLG, d, f); check("R1 flags read", d, 32'h0);
  endtask

  task automatic t_super_write();
    logic [31:0] d; logic f;
    wr(A_SUP, 32'hFFFF_FFFF);
    check("R3 pins all set", pins(), 32'hF000_00FF);
    rd(A_SUP, d, f); check("R2 reserved zero", d, 32'hF000_00FF);
    check("R4 no fault in supervisor", {31'b0, f}, 32'h0);
    wr(A_SUP, 32'h5000_00A5);
    check("R3 pins pattern", pins(), 32'h5000_00A5);
    check("R3 ctx_id", {28'b0, ctx_id}, 32'h5);
    wr(A_SUP, 32'hA000_005B);
    check("R3 pins pattern 2", pins(), 32'hA000_005B);
  endtask

  task automatic t_flags_rw();
    logic [31:0] d; logic f;
    wr(A_FLG, 32'hFFFF_FFFD);
    rd(A_FLG, d, f); check("R5 flags masked", d, 32'h5);
    check("R5 flags no fault", {31'b0, f}, 32'h0);
  endtask

  task automatic t_hw_flags();
    logic [31:0] d; logic f;
    wr(A_FLG, 32'h0);
    @(negedge clk); flag_upd_we = 3'b010; flag_upd_val = 3'b111;
    @(negedge clk); flag_upd_we = 3'b000;
    rd(A_FLG, d, f); check("R6 carry only", d, 32'h2);
    @(negedge clk); flag_upd_we = 3'b101; flag_upd_val = 3'b101;
    @(negedge clk); flag_upd_we = 3'b000;
    rd(A_FLG, d, f); check("R6 compare and overflow", d, 32'h7);
    @(negedge clk); flag_upd_we = 3'b001; flag_upd_val = 3'b000;
    @(negedge clk); flag_upd_we = 3'b000;
    rd(A_FLG, d, f); check("R6 clear compare", d, 32'h6);
  endtask

  task automatic t_priority();
    logic [31:0] d; logic f;
    @(negedge clk);
    spr_addr = A_FLG; spr_wdata = 32'h1; spr_we = 1'b1;
    flag_upd_we = 3'b111; flag_upd_val = 3'b110;
    @(negedge clk);
    spr_we = 1'b0; flag_upd_we = 3'b000;
    rd(A_FLG, d, f); check("R7 software wins", d, 32'h1);
  endtask

  task automatic t_decode();
    logic [31:0] d; logic f;
    wr(16'h1011, 32'h0000_0000);
    check("R8 other group no super change", pins(), 32'hA000_005B);
    wr(16'h1010, 32'h6);
    rd(A_FLG, d, f); check("R8 other group no flag change", d, 32'h1);
    rd(16'h0012, d, f); check("R8 unmapped reads zero", d, 32'h0);
    check("R8 unmapped no fault", {31'b0, f}, 32'h0);
  endtask

  task automatic t_idle();
    @(negedge clk); spr_addr = A_SUP; spr_re = 1'b0;
    #1 check("R9 idle read zero", spr_rdata, 32'h0);
  endtask

  task automatic t_user();
    logic [31:0] d; logic f;
    wr(A_SUP, 32'h3000_0006);
    check("R4 user mode entered", pins(), 32'h3000_0006);
    rd(A_SUP, d, f);
    check("R4 user read zero", d, 32'h0);
    check("R4 user read fault", {31'b0, f}, 32'h1);
    @(negedge clk);
    spr_addr = A_SUP; spr_wdata = 32'hF000_00FF; spr_we = 1'b1;
    #1 check("R4 user write fault", {31'b0, priv_fault}, 32'h1);
    @(negedge clk); spr_we = 1'b0;
    check("R4 user write dropped", pins(), 32'h3000_0006);
    wr(A_FLG, 32'h4);
    rd(A_FLG, d, f); check("R5 flags in user mode", d, 32'h4);
    check("R5 no fault in user mode", {31'b0, f}, 32'h0);
    do_reset();
    check("R1 reset restores supervisor", pins(), 32'h1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_super_write();
    t_flags_rw();
    t_hw_flags();
    t_priority();
    t_decode();
    t_idle();
    t_user();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule